// File: doc/BRIEF.md
# Logical Shift Unit with Condition Flags

This block is the logical-shift execution slice of an integer datapath. It takes a 32-bit operand and shifts it left or right with zero fill. The shift covers only the low 8, 16 or 32 bits chosen by a size code. It then produces the shifted value together with carry, extend, negative, zero and overflow flags. The issue stage supplies the count in one of two ways: as a 3-bit immediate field, or as a data-register value of which only the low six bits are used.

The operation is launched by a one-cycle valid strobe. Result and flags appear on registered outputs in the following cycle. Those outputs keep their values until the next strobe. The extend flag is state held inside the unit, because a shift by zero leaves it untouched. A separate memory-form input forces word size and a single-bit shift, for the one-position memory shift.

Top module: `lsh_unit`

## Requirements
- R1: With `dir_left`=1 the sized operand moves toward its most significant bit, and zeros enter at bit 0.
- R2: With `dir_left`=0 the sized operand moves toward bit 0, and zeros enter at the top bit of the selected size.
- R3: For a nonzero count, `flag_c` and `flag_x` both equal the last bit that left the sized operand. On a left shift this is the bit leaving the top position; on a right shift it is the bit leaving bit 0.
- R4: `size` encodes 00 = byte (8 bits), 01 = word (16 bits), 10 or 11 = long (32 bits). For byte and word, the operand bits above the selected size appear on `result` unchanged.
- R5: With `cnt_reg`=0 the count is `imm_cnt` for values 1 to 7, and 000 means a count of 8.
- R6: With `cnt_reg`=1 the count is `reg_cnt` modulo 64, so any value from 0 to 63 is honoured. A count at or above the size width gives a sized result of zero. In that case carry and extend take the last bit shifted out, which is 0 for a count above the width.
- R7: A count of zero returns the operand unchanged, clears `flag_c` and keeps `flag_x` at its previous value.
- R8: `mem_form`=1 forces word size and a count of exactly 1, whatever `size`, `cnt_reg`, `imm_cnt` and `reg_cnt` hold.
- R9: `flag_n` is the top bit of the sized result, `flag_z` is set exactly when the sized result is zero, and `flag_v` is always 0.
- R10: `out_valid` pulses in the cycle after each `in_valid` cycle. Without `in_valid`, `result` and all flags hold their values.
- R11: While `rst_n` is low, `out_valid`, `result` and every flag are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Launch strobe, one cycle per operation |
| dir_left | input | 1 | 1 = shift left, 0 = shift right |
| size | input | 2 | Operand size code (see R4) |
| cnt_reg | input | 1 | 1 = count from register, 0 = immediate |
| imm_cnt | input | 3 | Immediate count field, 000 = 8 |
| reg_cnt | input | 32 | Register count source, used modulo 64 |
| mem_form | input | 1 | Forces word size and count 1 |
| operand | input | 32 | Value to shift |
| out_valid | output | 1 | Result-ready pulse |
| result | output | 32 | Shifted value with untouched upper bits |
| flag_c | output | 1 | Carry |
| flag_x | output | 1 | Extend |
| flag_n | output | 1 | Negative |
| flag_z | output | 1 | Zero |
| flag_v | output | 1 | Overflow, always 0 |

## Verification
The assertions assume that `in_valid` is only a single-cycle strobe where the launch cycle matters. They also assume that `size`, `mem_form` and `operand` are settled at the launching edge, since the flag and pass-through checks look back one cycle at those inputs. The stimulus drives every input on the falling edge, raises `in_valid` for exactly one cycle and then lowers it for at least one cycle. Random count values cover the whole modulo-64 range. Directed cases place counts at zero, at the size width and just above it.

// File: rtl/lsh_pkg.sv
package lsh_pkg;
    localparam int LSH_DATA_W = 32;
    localparam int LSH_CNT_W  = 6;
    localparam int LSH_IMM_W  = 3;
    localparam int LSH_NSIZE  = 3;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10
    } lsh_size_e;

    typedef struct packed {
        logic                  valid;
        logic [LSH_DATA_W-1:0] result;
        logic                  c;
        logic                  x;
        logic                  n;
        logic                  z;
        logic                  v;
    } lsh_state_t;
endpackage

// File: rtl/lsh_count_sel.sv
module lsh_count_sel #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 6,
    parameter int IMM_W  = 3
) (
    input  logic              cnt_reg,
    input  logic [IMM_W-1:0]  imm_cnt,
    input  logic [DATA_W-1:0] reg_cnt,
    input  logic              mem_form,
    output logic [CNT_W-1:0]  cnt
);
    // an all-zero immediate field stands for the largest immediate count
    localparam logic [CNT_W-1:0] IMM_ZERO_CNT = CNT_W'(1 << IMM_W);
    localparam logic [CNT_W-1:0] ONE_CNT      = CNT_W'(1);

    logic [CNT_W-1:0] imm_eff;

    always_comb begin
        imm_eff = (imm_cnt == '0) ? IMM_ZERO_CNT : CNT_W'(imm_cnt);
        if (mem_form)
            cnt = ONE_CNT;
        else if (cnt_reg)
            cnt = reg_cnt[CNT_W-1:0];
        else
            cnt = imm_eff;
    end
endmodule

// File: rtl/lsh_lane.sv
module lsh_lane #(
    parameter int LANE_W = 8,
    parameter int CNT_W  = 6
) (
    input  logic [LANE_W-1:0] opnd,
    input  logic              dir_left,
    input  logic [CNT_W-1:0]  cnt,
    output logic [LANE_W-1:0] res,
    output logic              cout
);
    localparam int EXT_W = LANE_W + 1;

    logic [EXT_W-1:0] left_ext;
    logic [EXT_W-1:0] right_ext;
    logic [EXT_W-1:0] left_sh;
    logic [EXT_W-1:0] right_sh;

    always_comb begin
        // one guard bit catches the last bit leaving the lane
        left_ext  = {1'b0, opnd};
        right_ext = {opnd, 1'b0};
        left_sh   = left_ext << cnt;
        right_sh  = right_ext >> cnt;
        if (dir_left) begin
            res  = left_sh[LANE_W-1:0];
            cout = left_sh[LANE_W];
        end else begin
            res  = right_sh[EXT_W-1:1];
            cout = right_sh[0];
        end
    end
endmodule

// File: rtl/lsh_flags.sv
module lsh_flags #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] sized_res,
    input  logic [1:0]        size_idx,
    output logic              neg,
    output logic              zero
);
    localparam int BYTE_W = DATA_W / 4;
    localparam int WORD_W = DATA_W / 2;

    always_comb begin
        zero = (sized_res == '0);
        case (size_idx)
            2'd0:    neg = sized_res[BYTE_W-1];
            2'd1:    neg = sized_res[WORD_W-1];
            default: neg = sized_res[DATA_W-1];
        endcase
    end
endmodule

// File: rtl/lsh_unit.sv
module lsh_unit
    import lsh_pkg::*;
#(
    parameter int DATA_W = LSH_DATA_W,
    parameter int CNT_W  = LSH_CNT_W,
    parameter int IMM_W  = LSH_IMM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              dir_left,
    input  logic [1:0]        size,
    input  logic              cnt_reg,
    input  logic [IMM_W-1:0]  imm_cnt,
    input  logic [DATA_W-1:0] reg_cnt,
    input  logic              mem_form,
    input  logic [DATA_W-1:0] operand,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              flag_c,
    output logic              flag_x,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_v
);
    localparam int NLANE = LSH_NSIZE;

    logic [CNT_W-1:0]  cnt;
    logic [1:0]        size_idx;
    logic [DATA_W-1:0] lane_res [NLANE];
    logic [DATA_W-1:0] lane_mask[NLANE];
    logic              lane_c   [NLANE];
    logic [DATA_W-1:0] sized_res;
    logic [DATA_W-1:0] keep_mask;
    logic              sel_c;
    logic              neg;
    logic              zero;
    lsh_state_t        st_d;
    lsh_state_t        st_q;

    lsh_count_sel #(
        .DATA_W(DATA_W),
        .CNT_W (CNT_W),
        .IMM_W (IMM_W)
    ) u_cnt (
        .cnt_reg (cnt_reg),
        .imm_cnt (imm_cnt),
        .reg_cnt (reg_cnt),
        .mem_form(mem_form),
        .cnt     (cnt)
    );

    // one lane per operand size: byte, word, long
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        localparam int LW = DATA_W >> (NLANE - 1 - g);
        logic [LW-1:0] lres;
        lsh_lane #(
            .LANE_W(LW),
            .CNT_W (CNT_W)
        ) u_lane (
            .opnd    (operand[LW-1:0]),
            .dir_left(dir_left),
            .cnt     (cnt),
            .res     (lres),
            .cout    (lane_c[g])
        );
        if (LW < DATA_W) begin : g_ext
            assign lane_res[g]  = {{(DATA_W-LW){1'b0}}, lres};
            assign lane_mask[g] = {{(DATA_W-LW){1'b0}}, {LW{1'b1}}};
        end else begin : g_full
            assign lane_res[g]  = lres;
            assign lane_mask[g] = '1;
        end
    end

    always_comb begin
        if (mem_form)
            size_idx = 2'd1;
        else if (size == SZ_BYTE)
            size_idx = 2'd0;
        else if (size == SZ_WORD)
            size_idx = 2'd1;
        else
            size_idx = 2'd2;
        sized_res = lane_res[size_idx];
        keep_mask = ~lane_mask[size_idx];
        sel_c     = lane_c[size_idx];
    end

    lsh_flags #(
        .DATA_W(DATA_W)
    ) u_flags (
        .sized_res(sized_res),
        .size_idx (size_idx),
        .neg      (neg),
        .zero     (zero)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.result = sized_res | (operand & keep_mask);
            st_d.n      = neg;
            st_d.z      = zero;
            st_d.v      = 1'b0;
            if (cnt == '0) begin
                st_d.c = 1'b0;
            end else begin
                st_d.c = sel_c;
                st_d.x = sel_c;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign result    = st_q.result;
    assign flag_c    = st_q.c;
    assign flag_x    = st_q.x;
    assign flag_n    = st_q.n;
    assign flag_z    = st_q.z;
    assign flag_v    = st_q.v;
endmodule

// File: rtl/lsh_chk.sv
module lsh_chk #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              dir_left,
    input logic [1:0]        size,
    input logic              cnt_reg,
    input logic [IMM_W-1:0]  imm_cnt,
    input logic [DATA_W-1:0] reg_cnt,
    input logic              mem_form,
    input logic [DATA_W-1:0] operand,
    input logic              out_valid,
    input logic [DATA_W-1:0] result,
    input logic              flag_c,
    input logic              flag_x,
    input logic              flag_n,
    input logic              flag_z,
    input logic              flag_v
);
    localparam int BYTE_W = DATA_W / 4;
    localparam int WORD_W = DATA_W / 2;

    logic [DATA_W-1:0] in_mask;
    always_comb begin
        if (mem_form || size == 2'b01)
            in_mask = {{(DATA_W-WORD_W){1'b0}}, {WORD_W{1'b1}}};
        else if (size == 2'b00)
            in_mask = {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
        else
            in_mask = '1;
    end

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !flag_v);

    // R9
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (flag_z == ((result & $past(in_mask)) == '0)));

    // R10
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(flag_c) && $stable(flag_x)
                       && $stable(flag_n) && $stable(flag_z) && !out_valid));

    // R3
    carry_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flag_c) |-> flag_x);

    // R4
    upper_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mem_form && size == 2'b00)
            |=> (result[DATA_W-1:BYTE_W] == $past(operand[DATA_W-1:BYTE_W])));

    // R8
    mem_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mem_form)
            |=> (result[DATA_W-1:WORD_W] == $past(operand[DATA_W-1:WORD_W])));
endmodule

bind lsh_unit lsh_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (.*);

// File: tb/sim_lsh_unit.sv
module sim_lsh_unit;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          dir_left = 1'b0;
    logic [1:0]    size = 2'b00;
    logic          cnt_reg = 1'b0;
    logic [2:0]    imm_cnt = 3'b000;
    logic [DW-1:0] reg_cnt = '0;
    logic          mem_form = 1'b0;
    logic [DW-1:0] operand = '0;
    logic          out_valid;
    logic [DW-1:0] result;
    logic          flag_c, flag_x, flag_n, flag_z, flag_v;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;
    logic model_x = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsh_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dir_left(dir_left),
        .size(size), .cnt_reg(cnt_reg), .imm_cnt(imm_cnt), .reg_cnt(reg_cnt),
        .mem_form(mem_form), .operand(operand), .out_valid(out_valid),
        .result(result), .flag_c(flag_c), .flag_x(flag_x), .flag_n(flag_n),
        .flag_z(flag_z), .flag_v(flag_v)
    );

    task automatic check(input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // reference: shift one position at a time inside the sized field
    function automatic void model(
        input logic dl, input logic [1:0] sz, input logic creg,
        input logic [2:0] imm, input logic [DW-1:0] rc, input logic mem,
        input logic [DW-1:0] op, input logic xprev,
        output logic [DW-1:0] r, output logic c, output logic x,
        output logic n, output logic z);
        int w;
        int cnt;
        logic [DW-1:0] mask;
        logic [DW-1:0] s;
        w   = mem ? 16 : (sz == 2'b00 ? 8 : (sz == 2'b01 ? 16 : 32));
        cnt = mem ? 1 : (creg ? int'(rc % 64) : (imm == 3'd0 ? 8 : int'(imm)));
        mask = (w == 32) ? '1 : ((DW'(1) << w) - 1);
        s = op & mask;
        c = 1'b0;
        for (int i = 0; i < cnt; i++) begin
            if (dl) begin
                c = s[w-1];
                s = (s << 1) & mask;
            end else begin
                c = s[0];
                s = s >> 1;
            end
        end
        r = (op & ~mask) | s;
        x = (cnt == 0) ? xprev : c;
        n = s[w-1];
        z = (s == '0);
    endfunction

    task automatic run_op(input string req, input logic dl, input logic [1:0] sz,
                          input logic creg, input logic [2:0] imm,
                          input logic [DW-1:0] rc, input logic mem,
                          input logic [DW-1:0] op);
        logic [DW-1:0] er;
        logic ec, ex, en, ez;
        logic [DW-1:0] held;
        model(dl, sz, creg, imm, rc, mem, op, model_x, er, ec, ex, en, ez);
        @(negedge clk);
        dir_left = dl; size = sz; cnt_reg = creg; imm_cnt = imm;
        reg_cnt = rc; mem_form = mem; operand = op; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " R10 valid"}, DW'(out_valid), DW'(1));
        check({req, " result"}, result, er);
        check({req, " R3 carry"}, DW'(flag_c), DW'(ec));
        check({req, " R3 extend"}, DW'(flag_x), DW'(ex));
        check({req, " R9 neg"}, DW'(flag_n), DW'(en));
        check({req, " R9 zero"}, DW'(flag_z), DW'(ez));
        check({req, " R9 ovf"}, DW'(flag_v), DW'(0));
        model_x = ex;
        held = result;
        operand = ~op;
        @(negedge clk);
        check("R10 no valid", DW'(out_valid), DW'(0));
        check("R10 hold", result, held);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        check("R11 reset result", result, '0);
        check("R11 reset flags", DW'({out_valid, flag_c, flag_x, flag_n, flag_z, flag_v}), DW'(0));
        rst_n = 1'b1;

        // R1 byte left by 1, upper bits kept (R4)
        run_op("R1 R4", 1'b1, 2'b00, 1'b0, 3'd1, '0, 1'b0, 32'hABCD_1281);
        // R2 word right by 3
        run_op("R2", 1'b0, 2'b01, 1'b0, 3'd3, '0, 1'b0, 32'h1234_8005);
        // R5 immediate 000 means eight: byte left clears, carry = bit0
        run_op("R5", 1'b1, 2'b00, 1'b0, 3'd0, '0, 1'b0, 32'h0000_0081);
        // R7 zero count: extend kept at 1, carry cleared
        run_op("R7", 1'b0, 2'b10, 1'b1, 3'd0, 32'h0000_0040, 1'b0, 32'hDEAD_BEEF);
        // R6 count equal to width: word right by 16 -> carry = top bit
        run_op("R6 eq", 1'b0, 2'b01, 1'b1, 3'd0, 32'd16, 1'b0, 32'h5555_8000);
        // R6 count above width: byte left by 9 -> zero, carry 0
        run_op("R6 gt", 1'b1, 2'b00, 1'b1, 3'd0, 32'd9, 1'b0, 32'h0000_00FF);
        // R6 modulo 64: 65 acts as 1
        run_op("R6 mod", 1'b1, 2'b10, 1'b1, 3'd0, 32'd65, 1'b0, 32'h8000_0001);
        // R6 long right by 63
        run_op("R6 63", 1'b0, 2'b10, 1'b1, 3'd0, 32'd63, 1'b0, 32'hFFFF_FFFF);
        // R8 memory form forces word, count 1
        run_op("R8", 1'b1, 2'b10, 1'b1, 3'd5, 32'd20, 1'b1, 32'hF0F0_C001);
        run_op("R8 right", 1'b0, 2'b00, 1'b0, 3'd7, '0, 1'b1, 32'h0F0F_0003);
        // R4 size code 11 is long
        run_op("R4 long11", 1'b1, 2'b11, 1'b0, 3'd4, '0, 1'b0, 32'h8765_4321);

        for (int k = 0; k < 400; k++) begin
            logic [DW-1:0] rc;
            rc = (k % 5 == 0) ? DW'($urandom_range(0, 40)) : $urandom;
            run_op("rand R1 R2 R3 R5 R6", 1'($urandom), 2'($urandom), 1'($urandom),
                   3'($urandom), rc, ($urandom_range(0, 9) == 0), $urandom);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule